// File: doc/BRIEF.md
# Bit-Serial Compute-in-Memory Dot-Product Tile

The tile stores a square grid of single-bit weights and computes the signed dot product of one stored weight column with an activation vector. The activation vector arrives one bit-plane per clock, least significant plane first. The same plane goes to every row at once. In each row the weight bit of the selected column is ANDed with that row's activation bit. A fully pipelined binary adder tree counts the ones. A shift-and-add accumulator weights each count by the plane's bit position, and it subtracts the count of the top plane. The accumulated value is therefore the dot product with two's-complement activations.

A host fills the grid through a single-bit write port while the tile is idle. For each operation it chooses a column and a format: a wide format with 16 planes or a narrow format with 8 planes. It pulses `start`, drives the planes in the following cycles and waits for `done`. The sequencer moves through four named states. IDLE goes to FEED on an accepted start. FEED goes to DRAIN after the last plane. DRAIN goes to DONE when the accumulator has absorbed the last tree sum. DONE goes back to IDLE after one cycle.

Top module: `cim_tile`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` seen while `busy` is 0 is accepted at that clock edge. `busy` is 1 from the next cycle on, and `col_sel` and `mode_wide` are captured at that edge.
- R3: With `mode_wide`=1, sixteen planes are consumed. Plane i (bit i of each row's activation) is sampled at the (i+1)-th rising edge after the accepting edge. Bit r of `act_plane` belongs to row r.
- R4: With `mode_wide`=0, eight planes are consumed with the same timing. Each row's activation is an 8-bit value.
- R5: The top plane (bit 15 wide, bit 7 narrow) carries negative weight. `result` equals the sum over rows of weight bit times the signed activation.
- R6: `done` is a one-cycle pulse. It is first high in the cycle that follows the (N+9)-th rising edge after the accepting edge, where N is 16 in the wide format and 8 in the narrow format.
- R7: While `busy` is 0, `result` does not change. The result of the last operation stays readable until the next operation updates it.
- R8: A `start` pulse, or a change of `col_sel` or `mode_wide`, while `busy` is 1 has no effect on the running operation or its result.
- R9: A write with `wr_en`=1 while idle stores `wr_data` at row `wr_row` of column `wr_col`. A write attempted while `busy` is 1 is dropped.
- R10: Full-scale sums cannot overflow: all 256 weights at 1 with all activations at -32768 give -8388608, and with all activations at 32767 give 8388352.
- R11: Only the column captured at start contributes to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight write strobe (honoured only when idle) |
| wr_row | input | 8 | Row of the weight bit to write |
| wr_col | input | 8 | Column of the weight bit to write |
| wr_data | input | 1 | Weight bit value |
| col_sel | input | 8 | Column used by the next operation |
| mode_wide | input | 1 | 1: 16-plane format, 0: 8-plane format |
| act_plane | input | 256 | Current activation bit-plane, bit r for row r |
| start | input | 1 | Operation request pulse |
| busy | output | 1 | Operation in progress (FEED, DRAIN or DONE) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 26 | Signed dot product of the last operation |

## Verification
A weight write and a running dot product can fall in the same cycle, and the write would corrupt the column being reduced. The bench provokes this in the middle of the plane stream. It writes the inverse of a stored bit into the active column, pulses start again with the other format and moves `col_sel`, all in one cycle. The result and the done latency must match a model that holds the old weights. A follow-up operation with only row 0's activation set then exposes the bit at the ports. It shows that the write was dropped, and a later write made while idle does land.

// File: rtl/cim_pkg.sv
package cim_pkg;

    localparam int unsigned CIM_IDX_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FEED,
        ST_DRAIN,
        ST_DONE
    } cim_state_e;

    // Marker travelling beside each bit-plane through the tree pipeline
    typedef struct packed {
        logic                 vld;
        logic                 neg;   // sign plane, also the final plane
        logic [CIM_IDX_W-1:0] idx;
    } plane_tag_t;

endpackage

// File: rtl/cim_weight_store.sv
module cim_weight_store #(
    parameter int ROWS  = 256,
    parameter int COLS  = 256,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic             wr_data,
    input  logic [COL_W-1:0] rd_col,
    output logic [ROWS-1:0]  rd_word
);

    // Column-major: one entry holds every row's bit of one column
    logic [ROWS-1:0] mem [COLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_col][wr_row] <= wr_data;
        end
    end

    assign rd_word = mem[rd_col];

endmodule

// File: rtl/cim_adder_tree.sv
module cim_adder_tree #(
    parameter int ROWS  = 256,
    localparam int DEPTH = $clog2(ROWS),
    localparam int SUM_W = DEPTH + 1
) (
    input  logic             clk,
    input  logic [ROWS-1:0]  bits_in,
    output logic [SUM_W-1:0] sum
);

    localparam int NODES = ROWS - 1;
    localparam int TOTAL = 2 * ROWS - 1;

    logic [SUM_W-1:0] node [NODES];
    logic [SUM_W-1:0] heap [TOTAL];

    // Heap view: entries 0..NODES-1 are registered adders, the rest are leaves
    always_comb begin
        for (int k = 0; k < TOTAL; k++) begin
            if (k < NODES) begin
                heap[k] = node[k];
            end else begin
                heap[k] = SUM_W'(bits_in[k - NODES]);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NODES; k++) begin
            node[k] <= heap[2*k + 1] + heap[2*k + 2];
        end
    end

    assign sum = node[0];

endmodule

// File: rtl/cim_shift_acc.sv
module cim_shift_acc
    import cim_pkg::*;
#(
    parameter int SUM_W = 9,
    parameter int ACC_W = 26,
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  plane_tag_t              tag_in,
    input  logic [SUM_W-1:0]        tree_sum,
    output logic signed [ACC_W-1:0] acc_q,
    output logic                    fin_q
);

    plane_tag_t pipe [DEPTH];
    plane_tag_t head;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] acc_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= tag_in;
            for (int i = 1; i < DEPTH; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign head = pipe[DEPTH-1];

    always_comb begin
        term    = ACC_W'(tree_sum) << head.idx;
        base    = (head.idx == '0) ? '0 : acc_q;
        acc_nxt = head.neg ? (base - term) : (base + term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= head.vld && head.neg;
            if (head.vld) begin
                acc_q <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/cim_tile.sv
module cim_tile
    import cim_pkg::*;
#(
    parameter int ROWS        = 256,
    parameter int COLS        = 256,
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int DEPTH = $clog2(ROWS),
    localparam int SUM_W = DEPTH + 1,
    localparam int ACC_W = SUM_W + WIDE_BITS + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ROW_W-1:0]        wr_row,
    input  logic [COL_W-1:0]        wr_col,
    input  logic                    wr_data,
    input  logic [COL_W-1:0]        col_sel,
    input  logic                    mode_wide,
    input  logic [ROWS-1:0]         act_plane,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] result
);

    localparam logic [CIM_IDX_W-1:0] LAST_WIDE   = CIM_IDX_W'(WIDE_BITS - 1);
    localparam logic [CIM_IDX_W-1:0] LAST_NARROW = CIM_IDX_W'(NARROW_BITS - 1);

    cim_state_e           state_q, state_d;
    logic [CIM_IDX_W-1:0] plane_q;
    logic [COL_W-1:0]     col_q;
    logic                 wide_q;
    logic                 accept;
    logic                 last_plane;
    logic                 we_ok;
    logic                 fin;
    plane_tag_t           tag;
    logic [ROWS-1:0]      col_word;
    logic [ROWS-1:0]      products;
    logic [SUM_W-1:0]     tree_sum;

    assign accept     = (state_q == ST_IDLE) && start;
    assign last_plane = plane_q == (wide_q ? LAST_WIDE : LAST_NARROW);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operation context captured on acceptance, plane counter during FEED
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane_q <= '0;
            col_q   <= '0;
            wide_q  <= 1'b0;
        end else if (accept) begin
            plane_q <= '0;
            col_q   <= col_sel;
            wide_q  <= mode_wide;
        end else if (state_q == ST_FEED) begin
            plane_q <= plane_q + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)      state_d = ST_FEED;
            ST_FEED:  if (last_plane) state_d = ST_DRAIN;
            ST_DRAIN: if (fin)        state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        we_ok   = 1'b0;
        tag     = '0;
        unique case (state_q)
            ST_IDLE: begin
                busy  = 1'b0;
                we_ok = 1'b1;
            end
            ST_FEED: begin
                tag.vld = 1'b1;
                tag.neg = last_plane;
                tag.idx = plane_q;
            end
            ST_DRAIN: ;
            ST_DONE:  done = 1'b1;
        endcase
    end

    cim_weight_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
        .clk     (clk),
        .wr_en   (wr_en && we_ok),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .rd_col  (col_q),
        .rd_word (col_word)
    );

    assign products = col_word & act_plane;

    cim_adder_tree #(.ROWS(ROWS)) u_tree (
        .clk     (clk),
        .bits_in (products),
        .sum     (tree_sum)
    );

    cim_shift_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W), .DEPTH(DEPTH)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_in   (tag),
        .tree_sum (tree_sum),
        .acc_q    (result),
        .fin_q    (fin)
    );

endmodule

// File: rtl/cim_tile_chk.sv
module cim_tile_chk #(
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8,
    parameter int DEPTH       = 8,
    parameter int ACC_W       = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mode_wide,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] result
);

    logic [7:0] lat_q;
    logic       wide_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            wide_c <= 1'b0;
        end else if (!busy && start) begin
            lat_q  <= '0;
            wide_c <= mode_wide;
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(lat_q) == (wide_c ? WIDE_BITS + DEPTH + 1 : NARROW_BITS + DEPTH + 1))); // R6

    AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result)); // R7

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy); // R8

endmodule

bind cim_tile cim_tile_chk #(
    .WIDE_BITS   (WIDE_BITS),
    .NARROW_BITS (NARROW_BITS),
    .DEPTH       (DEPTH),
    .ACC_W       (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_wide (mode_wide),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/test_cim_tile.sv
module test_cim_tile;

    localparam int ROWS = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_row = '0;
    logic [7:0]   wr_col = '0;
    logic         wr_data = 1'b0;
    logic [7:0]   col_sel = '0;
    logic         mode_wide = 1'b0;
    logic [255:0] act_plane = '0;
    logic         start = 1'b0;
    logic         busy;
    logic         done;
    logic [25:0]  result;

    int checks = 0;
    int fails  = 0;
    bit wm [256][256];
    int act [ROWS];

    always #10 clk = ~clk;

    cim_tile i_cim_tile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .col_sel(col_sel), .mode_wide(mode_wide),
        .act_plane(act_plane), .start(start), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint expected(input int col);
        longint e = 0;
        for (int r = 0; r < ROWS; r++) if (wm[col][r]) e += act[r];
        return e;
    endfunction

    task automatic write_bit(input int row, input int col, input bit d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 8'(row); wr_col = 8'(col); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wm[col][row] = d;
    endtask

    // Runs one operation; inj provokes a write, a start, a format and column change mid-run
    task automatic run_op(input int col, input bit wide, input bit inj, input string req);
        int n = wide ? 16 : 8;
        int lat;
        longint got, exp;
        logic [25:0] held;
        exp = expected(col);
        @(negedge clk);
        col_sel = 8'(col); mode_wide = wide; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", longint'(busy), 1);
        lat = 0;
        for (int i = 0; i < n; i++) begin
            for (int r = 0; r < ROWS; r++) act_plane[r] = act[r][i];
            if (inj && i == 3) begin
                start = 1'b1; mode_wide = ~wide; col_sel = 8'(col + 1);
                wr_en = 1'b1; wr_row = 8'd0; wr_col = 8'(col); wr_data = ~wm[col][0];
            end
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            lat++;
        end
        act_plane = '0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        got = longint'($signed(result));
        check(got == exp, req, got, exp);
        check(lat == n + 9, "R6 latency", lat, n + 9);
        held = result;
        @(negedge clk);
        check(done === 1'b0, "R6 pulse", longint'(done), 0);
        repeat (3) @(negedge clk);
        check(result === held, "R7", longint'($signed(result)), longint'($signed(held)));
    endtask

    task automatic random_acts(input bit wide);
        for (int r = 0; r < ROWS; r++)
            act[r] = wide ? int'($signed(16'($urandom()))) : int'($signed(8'($urandom())));
    endtask

    task automatic fill_acts(input int v);
        for (int r = 0; r < ROWS; r++) act[r] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cols [3] = '{0, 5, 200};
        void'($urandom(32'd90210));
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1 busy", longint'(busy), 0);
        check(done === 1'b0, "R1 done", longint'(done), 0);
        check(result === '0, "R1 result", longint'($signed(result)), 0);
        rst_n = 1'b1;

        // R9: fill three columns with random bits and column 255 with ones
        foreach (cols[k]) for (int r = 0; r < ROWS; r++) write_bit(r, cols[k], 1'($urandom()));
        for (int r = 0; r < ROWS; r++) write_bit(r, 255, 1'b1);

        // R3, R4, R11: random patterns over several columns and both formats
        for (int t = 0; t < 8; t++) begin
            bit w = t[0];
            random_acts(w);
            run_op(cols[t % 3], w, 1'b0, w ? "R3/R11 wide" : "R4/R11 narrow");
        end

        // R5, R10: full-scale corners
        fill_acts(-32768); run_op(255, 1'b1, 1'b0, "R10/R5 wide min");
        fill_acts(32767);  run_op(255, 1'b1, 1'b0, "R10 wide max");
        fill_acts(-128);   run_op(255, 1'b0, 1'b0, "R5 narrow min");
        fill_acts(-1);     run_op(5,   1'b0, 1'b0, "R5 narrow minus one");
        fill_acts(0);      run_op(200, 1'b1, 1'b0, "R3 zero acts");

        // R8, R9: start, format, column and weight write all during a run
        random_acts(1'b1);
        run_op(0, 1'b1, 1'b1, "R8/R9 busy interference");
        fill_acts(0); act[0] = 1;
        run_op(0, 1'b1, 1'b0, "R9 busy write dropped");
        write_bit(0, 0, ~wm[0][0]);
        run_op(0, 1'b1, 1'b0, "R9 idle write lands");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule